// File: doc/BRIEF.md
# Execution-Unit Bus Request Decoder

This block acts on a one-cycle request field from an execution unit. Each request carries a command and an address-space code. Read and write commands go to one of four byte-wide spaces, all modelled inside the block:

- a program space, which is read-only and filled by a fixed formula;
- a direct data RAM;
- an indirect data RAM;
- a special-function/bit RAM.

The byte address always comes from the unit's working register r3. Write data is the low byte of the unit's data-out register. Read data lands in a return register and is presented zero-extended to 16 bits.

Two commands ignore the address-space code. They set or clear a global interrupt-enable flag.

Each request acts on the clock edge that ends its cycle, with no wait states. A read strobed in one cycle can therefore be consumed in the next. Back-to-back requests in consecutive cycles are allowed.

Top module: `bus_req_unit`

## Requirements
- R1: Request bits [2:0] are the command: 0 idle, 1 write, 2 read, 3 clear interrupt enable, 4 set interrupt enable.
- R2: Request bits [6:4] choose the space: 0 program, 1 direct data, 2 indirect data, 3 special-function; bits 3 and 7 have no effect.
- R3: The byte index is taken from the low log2(depth) bits of the r3 input, so addresses wrap at the space depth (program 256, direct 128, indirect 256, special 128 bytes by default).
- R4: A read strobed in cycle k shows {8'h00, byte} on the return output from the edge that ends cycle k.
- R5: Command 4 sets the interrupt-enable output on the next edge, and command 3 clears it, whatever the space bits hold.
- R6: Synchronous reset clears the interrupt enable and the return register, and reset wins over a request in the same cycle. Apart from reset, the enable changes only on commands 3 and 4.
- R7: The return output holds its value in every cycle without a valid read.
- R8: Program space is read-only: a write to it is dropped. Its byte at index i is (13*i + 0x5A) mod 256.
- R9: Commands 5 to 7 do nothing. Reads and writes with space codes 4 to 7 do nothing.
- R10: A write stores the low byte of the data-out input. The same index in different spaces holds distinct bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request field, valid for one cycle |
| r3_i | input | 16 | Working register r3, source of the address |
| dout_i | input | 16 | Data-out register; low byte is written |
| ret_o | output | 16 | Return register, {8'h00, read byte} |
| irq_en_o | output | 1 | Global interrupt enable |

## Verification
A read lands in the return register at the same edge at which the following request may already be a write to the very same byte. So the return value presented in a cycle can coincide with a store to its source. The bench reads a direct-data byte and then writes a new value to that address in the very next cycle. It checks that the return output still carries the old byte after the write edge, and that a later read returns the new one. A reset raised in the same cycle as an interrupt-enable request is also checked, to confirm that reset wins.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;

    localparam int NUM_SPACES = 4;

    // Command field values (request bits [2:0])
    localparam logic [2:0] CMD_IDLE    = 3'd0;
    localparam logic [2:0] CMD_WRITE   = 3'd1;
    localparam logic [2:0] CMD_READ    = 3'd2;
    localparam logic [2:0] CMD_IRQ_OFF = 3'd3;
    localparam logic [2:0] CMD_IRQ_ON  = 3'd4;

    typedef enum logic [1:0] {
        SP_CODE     = 2'd0,
        SP_DIRECT   = 2'd1,
        SP_INDIRECT = 2'd2,
        SP_SPECIAL  = 2'd3
    } space_e;

    typedef struct packed {
        logic                  rd;
        logic                  wr;
        logic                  irq_set;
        logic                  irq_clr;
        logic [NUM_SPACES-1:0] sel;
    } action_t;

    // Fixed content of the read-only program space
    function automatic logic [7:0] code_byte(input logic [7:0] idx);
        logic [7:0] prod;
        prod = idx * 8'd13;
        return prod + 8'h5A;
    endfunction

endpackage

// File: rtl/req_decode.sv
module req_decode
    import bus_req_pkg::*;
(
    input  logic [7:0] req_i,
    output action_t    act_o
);
    logic [2:0] cmd;
    logic [2:0] space;
    logic       space_ok;
    logic       unused_req;

    assign cmd        = req_i[2:0];
    assign space      = req_i[6:4];
    assign unused_req = req_i[7] ^ req_i[3];
    assign space_ok   = (space < 3'(NUM_SPACES));

    always_comb begin
        act_o = '0;
        for (int s = 0; s < NUM_SPACES; s++)
            act_o.sel[s] = space_ok && (space == 3'(s));
        unique case (cmd)
            CMD_WRITE:   act_o.wr      = space_ok;
            CMD_READ:    act_o.rd      = space_ok;
            CMD_IRQ_OFF: act_o.irq_clr = 1'b1;
            CMD_IRQ_ON:  act_o.irq_set = 1'b1;
            default:     act_o         = '{default: '0, sel: act_o.sel};
        endcase
    end

    // R1: at most one action per request; R2: at most one space selected
    always_comb begin
        p_one_action_r1: assert ($onehot0({act_o.rd, act_o.wr, act_o.irq_set, act_o.irq_clr}));
        p_one_space_r2:  assert ($onehot0(act_o.sel));
    end

endmodule

// File: rtl/byte_space.sv
module byte_space #(
    parameter int DEPTH     = 256,
    parameter bit READ_ONLY = 1'b0,
    localparam int IW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    generate
        if (READ_ONLY) begin : g_rom
            logic [7:0] idx8;
            logic       unused_rom;
            assign idx8       = 8'(idx_i);
            assign rdata_o    = bus_req_pkg::code_byte(idx8);
            assign unused_rom = ^wdata_i;

            // R8: the decoder never routes a write into read-only space
            p_rom_no_write_r8: assert property (@(posedge clk) disable iff (rst)
                !we_i);
        end else begin : g_ram
            logic [7:0] mem [DEPTH];
            logic       unused_ram;
            assign unused_ram = rst;

            always_ff @(posedge clk) begin
                if (we_i)
                    mem[idx_i] <= wdata_i;
            end
            assign rdata_o = mem[idx_i];
        end
    endgenerate

endmodule

// File: rtl/bus_req_unit.sv
module bus_req_unit
    import bus_req_pkg::*;
#(
    parameter int CODE_DEPTH     = 256,
    parameter int DIRECT_DEPTH   = 128,
    parameter int INDIRECT_DEPTH = 256,
    parameter int SPECIAL_DEPTH  = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  req_i,
    input  logic [15:0] r3_i,
    input  logic [15:0] dout_i,
    output logic [15:0] ret_o,
    output logic        irq_en_o
);
    localparam int DEPTHS [NUM_SPACES] = '{CODE_DEPTH, DIRECT_DEPTH,
                                           INDIRECT_DEPTH, SPECIAL_DEPTH};

    action_t    act;
    logic [7:0] rd_bytes [NUM_SPACES];
    logic [7:0] rd_byte;
    logic [7:0] ret_q;
    logic       irq_en_q;
    logic       unused_bits;

    assign unused_bits = ^{r3_i, dout_i[15:8]};

    req_decode i_decode (
        .req_i (req_i),
        .act_o (act)
    );

    generate
        for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
            localparam int SIW = $clog2(DEPTHS[s]);
            byte_space #(
                .DEPTH     (DEPTHS[s]),
                .READ_ONLY (s == int'(SP_CODE))
            ) i_space (
                .clk     (clk),
                .rst     (rst),
                .we_i    (act.wr && act.sel[s] && (s != int'(SP_CODE))),
                .idx_i   (r3_i[SIW-1:0]),
                .wdata_i (dout_i[7:0]),
                .rdata_o (rd_bytes[s])
            );
        end
    endgenerate

    always_comb begin
        rd_byte = '0;
        for (int s = 0; s < NUM_SPACES; s++)
            if (act.sel[s]) rd_byte = rd_bytes[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q    <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (act.rd)      ret_q    <= rd_byte;
            if (act.irq_set) irq_en_q <= 1'b1;
            if (act.irq_clr) irq_en_q <= 1'b0;
        end
    end

    assign ret_o    = {8'h00, ret_q};
    assign irq_en_o = irq_en_q;

    p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
        act.irq_set |=> irq_en_o);
    p_irq_clr_r5: assert property (@(posedge clk) disable iff (rst)
        act.irq_clr |=> !irq_en_o);
    p_irq_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !(act.irq_set || act.irq_clr) |=> $stable(irq_en_o));
    p_ret_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !act.rd |=> $stable(ret_o));
    p_read_lands_r4: assert property (@(posedge clk) disable iff (rst)
        act.rd |=> (ret_o == {8'h00, $past(rd_byte)}));

endmodule

// File: tb/test_bus_req_unit.sv
`timescale 1ns/1ps
module test_bus_req_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_i = '0;
    logic [15:0] r3_i = '0;
    logic [15:0] dout_i = '0;
    logic [15:0] ret_o;
    logic        irq_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bus_req_unit i_bus_req_unit (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .r3_i     (r3_i),
        .dout_i   (dout_i),
        .ret_o    (ret_o),
        .irq_en_o (irq_en_o)
    );

    // {req, r3, dout, expected ret, expected irq_en, requirement number}
    localparam int NV = 24;
    localparam logic [64:0] VEC [NV] = '{
        {8'h02, 16'h0000, 16'h0000, 16'h005A, 1'b0, 8'd8},  // R8 program byte 0
        {8'h02, 16'h0105, 16'h0000, 16'h009B, 1'b0, 8'd3},  // R3 wrap in program space
        {8'h11, 16'h0010, 16'h12A5, 16'h009B, 1'b0, 8'd7},  // R7 write leaves return
        {8'h12, 16'h0010, 16'h0000, 16'h00A5, 1'b0, 8'd10}, // R10 low byte stored
        {8'h21, 16'h0010, 16'h0033, 16'h00A5, 1'b0, 8'd7},  // R7
        {8'h22, 16'h0010, 16'h0000, 16'h0033, 1'b0, 8'd4},  // R4 indirect read
        {8'h12, 16'h0010, 16'h0000, 16'h00A5, 1'b0, 8'd10}, // R10 spaces distinct
        {8'h04, 16'h0000, 16'h0000, 16'h00A5, 1'b1, 8'd5},  // R5 enable
        {8'h31, 16'h0005, 16'h007E, 16'h00A5, 1'b1, 8'd6},  // R6 write keeps enable
        {8'h32, 16'h0005, 16'h0000, 16'h007E, 1'b1, 8'd4},  // R4 special read
        {8'h33, 16'h0000, 16'h0000, 16'h007E, 1'b0, 8'd5},  // R5 clear, space bits set
        {8'h01, 16'h0000, 16'h00FF, 16'h007E, 1'b0, 8'd8},  // R8 write program
        {8'h02, 16'h0000, 16'h0000, 16'h005A, 1'b0, 8'd8},  // R8 unchanged
        {8'h15, 16'h0010, 16'h0099, 16'h005A, 1'b0, 8'd9},  // R9 cmd 5
        {8'h16, 16'h0010, 16'h0099, 16'h005A, 1'b0, 8'd9},  // R9 cmd 6
        {8'h17, 16'h0010, 16'h0099, 16'h005A, 1'b0, 8'd9},  // R9 cmd 7
        {8'h41, 16'h0010, 16'h0044, 16'h005A, 1'b0, 8'd9},  // R9 space 4 write
        {8'h12, 16'h0010, 16'h0000, 16'h00A5, 1'b0, 8'd9},  // R9 direct unchanged
        {8'h52, 16'h0010, 16'h0000, 16'h00A5, 1'b0, 8'd9},  // R9 space 5 read
        {8'h11, 16'h0090, 16'h005C, 16'h00A5, 1'b0, 8'd3},  // R3 wrap at 128
        {8'h12, 16'h0010, 16'h0000, 16'h005C, 1'b0, 8'd3},  // R3
        {8'h8A, 16'h0010, 16'h0000, 16'h002A, 1'b0, 8'd2},  // R2 bits 7,3 ignored
        {8'h00, 16'hFFFF, 16'hFFFF, 16'h002A, 1'b0, 8'd1},  // R1 idle
        {8'h02, 16'h0001, 16'h0000, 16'h0067, 1'b0, 8'd1}   // R1 read
    };

    task automatic check(input int rq, input logic [15:0] exp_ret, input logic exp_irq);
        checks++;
        if (ret_o !== exp_ret || irq_en_o !== exp_irq) begin
            fails++;
            $display("FAIL R%0d: ret=%h irq=%b expected ret=%h irq=%b",
                     rq, ret_o, irq_en_o, exp_ret, exp_irq);
        end
    endtask

    task automatic apply(input logic [7:0] rq, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        req_i = rq; r3_i = a; dout_i = d;
        @(posedge clk);
        #1;
        req_i = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #0.5;
        check(6, 16'h0000, 1'b0); // R6 reset state

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][64:57], VEC[i][56:41], VEC[i][40:25]);
            check(int'(VEC[i][7:0]), VEC[i][24:9], VEC[i][8]);
        end

        // R4/R10: write to the byte just read, in the next cycle
        apply(8'h12, 16'h0020, 16'h0000);
        apply(8'h11, 16'h0020, 16'h00C3);
        apply(8'h12, 16'h0020, 16'h0000);
        apply(8'h11, 16'h0020, 16'h0066);
        check(4, 16'h00C3, 1'b0);   // R4 old byte still returned
        apply(8'h12, 16'h0020, 16'h0000);
        check(10, 16'h0066, 1'b0);  // R10 new byte visible

        // R6: reset wins over enable request
        apply(8'h04, 16'h0000, 16'h0000);
        check(5, 16'h0066, 1'b1);
        @(negedge clk);
        rst = 1'b1; req_i = 8'h04;
        @(posedge clk); #1;
        check(6, 16'h0000, 1'b0);
        @(negedge clk);
        rst = 1'b0; req_i = '0;
        @(posedge clk); #1;
        check(6, 16'h0000, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule